// File: doc/BRIEF.md
# Programmable-Trigger Interrupt Controller

This block collects up to 32 interrupt lines, synchronous to the block clock, into one interrupt output. Each line has its own trigger type, set by one bit of a mode vector and one bit of a polarity vector. It can be an active-high or active-low level, or a rising or falling edge. Qualified events land in a pending vector. Level-triggered bits follow their input. Edge-triggered bits stay set until software acknowledges them by writing ones.

An enable vector masks the pending bits, and the masked result drives the single output. The output can signal as a level, meaning anything is pending and enabled. It can also signal as a one-cycle pulse, raised whenever a masked bit newly becomes set. Either form can be active-high or active-low. Software can inject events through a write-only force register. A simple synchronous register port carries all configuration: a select, a write strobe, a byte address and 32-bit data. Reads return data combinationally from the address.

Top module: `irq_trigger_ctrl`

## Requirements
- R1: After reset, every readable register reads 0, and with all inputs held high `irq_out` is 1 (the output is inactive with output polarity 0).
- R2: Register offsets are fixed: enable 0x00, pending 0x04, source mode 0x08, source polarity 0x0C, output mode 0x10, output polarity 0x14, force 0x18. Enable, mode and polarity read back all 32 bits. The output mode and output polarity registers keep bit 0 only, and their other bits read 0. Force reads 0.
- R3: With source mode bit 0 (level), the pending bit after each clock edge equals the input sampled at that edge, inverted when the polarity bit is 0.
- R4: With source mode bit 1 (edge), a pending bit sets on a 0-to-1 input change when the polarity bit is 1, or on a 1-to-0 change when it is 0. The bit then stays set after the input returns.
- R5: Writing pending at 0x04 clears each edge-mode bit whose data bit is 1 and leaves bits written 0 unchanged, so all-ones clears every edge bit. A level bit whose input is still active stays set.
- R6: When an edge event and a clear hit the same bit at the same clock edge, the bit ends up set.
- R7: Writing 1 to a force bit at 0x18 sets that pending bit at the write's clock edge. In edge mode it stays set. In level mode it falls back to the input level at the next edge.
- R8: In level output mode, the output is active exactly when (pending AND enable) is nonzero.
- R9: Output polarity bit 0 = 1 makes active mean `irq_out` high; 0 makes active mean `irq_out` low.
- R10: In output mode 1 (pulse), the output is active for exactly one cycle after an edge at which a bit of (pending AND enable) newly sets, and inactive otherwise.
- R11: A write to the unused offset 0x1C changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register port select |
| bus_wr | input | 1 | Write strobe, used with bus_sel |
| bus_addr | input | 5 | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_in | input | N_SRC | Interrupt source lines, synchronous to clk |
| irq_out | output | 1 | Combined interrupt output |

## Verification
The assertions assume every source line is already synchronous to `clk`, so the edge detector never sees a metastable sample. They also assume register writes are exactly the cycles where `bus_sel` and `bus_wr` are both high, and that reset is applied before the first checked edge. The stimulus changes sources and bus signals only on the falling clock edge. It holds the source lines steady while reconfiguring, and acknowledges the pending vector after every mode or polarity change, so leftover events from an old setting never mix into an expected value.

// File: rtl/irq_trigger_ctrl.sv
`timescale 1ns/1ps
module irq_trigger_ctrl #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [4:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [N_SRC-1:0] src_in,
  output logic             irq_out
);
  localparam logic [2:0] IX_EN    = 3'd0;
  localparam logic [2:0] IX_PEND  = 3'd1;
  localparam logic [2:0] IX_SMODE = 3'd2;
  localparam logic [2:0] IX_SPOL  = 3'd3;
  localparam logic [2:0] IX_OMODE = 3'd4;
  localparam logic [2:0] IX_OPOL  = 3'd5;
  localparam logic [2:0] IX_FRC   = 3'd6;
  localparam int PAD = 32 - N_SRC;

  logic [N_SRC-1:0] en_r, mode_r, pol_r, pend_r, src_q, masked_q;
  logic             omode_r, opol_r;

  wire unused_addr_bits = ^bus_addr[1:0];
  wire [2:0] idx = bus_addr[4:2];
  wire we = bus_sel & bus_wr;
  wire [N_SRC-1:0] wd = bus_wdata[N_SRC-1:0];
  wire [N_SRC-1:0] clr = (we && idx == IX_PEND) ? wd : '0;
  wire [N_SRC-1:0] frc = (we && idx == IX_FRC)  ? wd : '0;

  wire [N_SRC-1:0] lvl_hit  = src_in ~^ pol_r;
  wire [N_SRC-1:0] edge_hit = (src_in & ~src_q & pol_r) | (~src_in & src_q & ~pol_r);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_r    <= '0;
      mode_r  <= '0;
      pol_r   <= '0;
      omode_r <= 1'b0;
      opol_r  <= 1'b0;
    end else if (we) begin
      case (idx)
        IX_EN:    en_r    <= wd;
        IX_SMODE: mode_r  <= wd;
        IX_SPOL:  pol_r   <= wd;
        IX_OMODE: omode_r <= bus_wdata[0];
        IX_OPOL:  opol_r  <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_in;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n)
        pend_r[i] <= 1'b0;
      else if (mode_r[i])
        pend_r[i] <= (pend_r[i] & ~clr[i]) | edge_hit[i] | frc[i];
      else
        pend_r[i] <= lvl_hit[i] | frc[i];
    end
  end

  wire [N_SRC-1:0] masked = pend_r & en_r;

  always_ff @(posedge clk) begin
    if (!rst_n) masked_q <= '0;
    else        masked_q <= masked;
  end

  wire any_on = |masked;
  wire fresh  = |(masked & ~masked_q);
  wire active = omode_r ? fresh : any_on;
  assign irq_out = active ~^ opol_r;

  function automatic logic [31:0] widen(input logic [N_SRC-1:0] v);
    return {{PAD{1'b0}}, v};
  endfunction

  always_comb begin
    case (idx)
      IX_EN:    bus_rdata = widen(en_r);
      IX_PEND:  bus_rdata = widen(pend_r);
      IX_SMODE: bus_rdata = widen(mode_r);
      IX_SPOL:  bus_rdata = widen(pol_r);
      IX_OMODE: bus_rdata = {31'd0, omode_r};
      IX_OPOL:  bus_rdata = {31'd0, opol_r};
      default:  bus_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/irq_trigger_ctrl_chk.sv
`timescale 1ns/1ps
module irq_trigger_ctrl_chk #(
  parameter int N_SRC = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [4:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [N_SRC-1:0] src_in,
  input logic [N_SRC-1:0] pend_r,
  input logic [N_SRC-1:0] en_r,
  input logic [N_SRC-1:0] mode_r,
  input logic [N_SRC-1:0] pol_r,
  input logic             opol_r,
  input logic             irq_out
);
  wire unused_chk_bits = ^bus_addr[1:0];
  wire we = bus_sel & bus_wr;
  wire [N_SRC-1:0] c_clr = (we && bus_addr[4:2] == 3'd1) ? bus_wdata[N_SRC-1:0] : '0;
  wire [N_SRC-1:0] c_frc = (we && bus_addr[4:2] == 3'd6) ? bus_wdata[N_SRC-1:0] : '0;

  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pend_r ^ $past(src_in ~^ pol_r)) & ~$past(mode_r) & ~$past(c_frc)) == '0)); // R3

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_r & mode_r & ~c_clr) & ~pend_r) == '0)); // R4

  AST_FORCE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(c_frc) & ~pend_r) == '0)); // R7

  AST_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_r & en_r) == '0) |-> (irq_out == !opol_r)); // R8

  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && bus_addr[4:2] == 3'd7) |=> ($stable(en_r) && $stable(mode_r) && $stable(pol_r))); // R11
endmodule

bind irq_trigger_ctrl irq_trigger_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .src_in(src_in),
  .pend_r(pend_r), .en_r(en_r), .mode_r(mode_r), .pol_r(pol_r),
  .opol_r(opol_r), .irq_out(irq_out)
);

// File: tb/irq_trigger_ctrl_test.sv
`timescale 1ns/1ps
module irq_trigger_ctrl_test;
  localparam logic [4:0] A_EN = 5'h00, A_PEND = 5'h04, A_SMODE = 5'h08, A_SPOL = 5'h0C;
  localparam logic [4:0] A_OMODE = 5'h10, A_OPOL = 5'h14, A_FRC = 5'h18, A_GAP = 5'h1C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] src_in = '1;
  logic irq_out;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_trigger_ctrl uut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_in(src_in), .irq_out(irq_out));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] edgef(input logic [31:0] o, input logic [31:0] n, input logic [31:0] p);
    return (n & ~o & p) | (~n & o & ~p);
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    step();
    for (int a = 0; a < 8; a++) begin
      rd(5'(a * 4), v);
      chk($sformatf("R1 reset read offset %0h", a * 4), v, 32'd0);
    end
    chk("R1 reset irq_out", {31'd0, irq_out}, 32'd1);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wr(A_EN, 32'hA5A5_5A5A);    rd(A_EN, v);    chk("R2 enable readback", v, 32'hA5A5_5A5A);
    wr(A_SMODE, 32'h1234_5678); rd(A_SMODE, v); chk("R2 mode readback", v, 32'h1234_5678);
    wr(A_SPOL, 32'h8765_4321);  rd(A_SPOL, v);  chk("R2 polarity readback", v, 32'h8765_4321);
    wr(A_OMODE, 32'hFFFF_FFFF); rd(A_OMODE, v); chk("R2 output mode bit0", v, 32'd1);
    wr(A_OPOL, 32'hFFFF_FFFE);  rd(A_OPOL, v);  chk("R2 output polarity bit0", v, 32'd0);
    wr(A_FRC, 32'd0);           rd(A_FRC, v);   chk("R2 force reads zero", v, 32'd0);
    wr(A_GAP, 32'hFFFF_FFFF);
    rd(A_EN, v);    chk("R11 enable after gap write", v, 32'hA5A5_5A5A);
    rd(A_SMODE, v); chk("R11 mode after gap write", v, 32'h1234_5678);
    rd(A_SPOL, v);  chk("R11 polarity after gap write", v, 32'h8765_4321);
    rd(A_OMODE, v); chk("R11 output mode after gap write", v, 32'd1);
    rd(A_GAP, v);   chk("R11 gap reads zero", v, 32'd0);
    wr(A_EN, 0); wr(A_SMODE, 0); wr(A_SPOL, 0); wr(A_OMODE, 0); wr(A_OPOL, 0);
    wr(A_PEND, '1);
  endtask

  task automatic t_level();
    logic [31:0] v;
    logic [31:0] pol = 32'h0000_FFFF;
    wr(A_SPOL, pol);
    src_in = 32'h00F0_0F00; step();
    rd(A_PEND, v); chk("R3 level follows input", v, ~(src_in ^ pol));
    wr(A_PEND, '1);
    rd(A_PEND, v); chk("R5 level bit survives clear", v, ~(src_in ^ pol));
    src_in = 32'hFFFF_0000; step();
    rd(A_PEND, v); chk("R3 level tracks new input", v, ~(src_in ^ pol));
  endtask

  task automatic t_edge();
    logic [31:0] v, e;
    logic [31:0] pol = 32'h0000_FFFF;
    logic [31:0] b1 = 32'h0F0F_0F0F, b2 = 32'h3333_3333;
    wr(A_SMODE, '1);
    src_in = b1; step(); step();
    wr(A_PEND, '1);
    rd(A_PEND, v); chk("R5 all-ones clears edge bits", v, 32'd0);
    src_in = b2; step();
    e = edgef(b1, b2, pol);
    rd(A_PEND, v); chk("R4 edge detect per polarity", v, e);
    src_in = b1; step();
    e |= edgef(b2, b1, pol);
    rd(A_PEND, v); chk("R4 edge bits sticky after return", v, e);
    wr(A_PEND, 32'd0);
    rd(A_PEND, v); chk("R5 zero write leaves pending", v, e);
    wr(A_PEND, 32'h0000_FFFF);
    e &= 32'hFFFF_0000;
    rd(A_PEND, v); chk("R5 partial clear", v, e);
    wr(A_PEND, '1);
    rd(A_PEND, v); chk("R5 full clear", v, 32'd0);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    src_in[3] = 1'b0; step();
    rd(A_PEND, v); chk("R4 falling edge ignored on rising source", v, 32'd0);
    @(negedge clk);
    src_in[3] = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_PEND; bus_wdata = 32'h0000_0008;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd(A_PEND, v); chk("R6 event beats same-cycle clear", v, 32'h0000_0008);
  endtask

  task automatic t_force();
    logic [31:0] v, l;
    wr(A_PEND, '1);
    wr(A_FRC, 32'h8000_0001);
    rd(A_PEND, v); chk("R7 force sets edge bits", v, 32'h8000_0001);
    step();
    rd(A_PEND, v); chk("R7 forced edge bits stay", v, 32'h8000_0001);
    wr(A_PEND, '1);
    wr(A_SMODE, 32'd0);
    l = ~(src_in ^ 32'h0000_FFFF);
    wr(A_FRC, 32'h0000_0010);
    rd(A_PEND, v); chk("R7 force on inactive level bit", v, l | 32'h10);
    step();
    rd(A_PEND, v); chk("R7 level bit returns to input", v, l);
  endtask

  task automatic t_out();
    logic [31:0] l;
    l = ~(src_in ^ 32'h0000_FFFF);
    wr(A_EN, 32'd0);
    chk("R8 masked, low-active idle", {31'd0, irq_out}, 32'd1);
    wr(A_OPOL, 32'd1);
    chk("R9 masked, high-active idle", {31'd0, irq_out}, 32'd0);
    wr(A_EN, l);
    chk("R8 R9 enabled pending high-active", {31'd0, irq_out}, 32'd1);
    wr(A_EN, ~l);
    chk("R8 enable misses pending", {31'd0, irq_out}, 32'd0);
    wr(A_OPOL, 32'd0); wr(A_EN, l);
    chk("R9 enabled pending low-active", {31'd0, irq_out}, 32'd0);
  endtask

  task automatic t_pulse();
    wr(A_EN, 32'd0); wr(A_SMODE, '1); wr(A_PEND, '1);
    wr(A_OPOL, 32'd1); wr(A_OMODE, 32'd1); wr(A_EN, 32'h0000_0020);
    chk("R10 pulse idle", {31'd0, irq_out}, 32'd0);
    wr(A_FRC, 32'h0000_0020);
    chk("R10 pulse asserted", {31'd0, irq_out}, 32'd1);
    step();
    chk("R10 pulse one cycle", {31'd0, irq_out}, 32'd0);
    step();
    chk("R10 no repeat while pending", {31'd0, irq_out}, 32'd0);
    wr(A_OPOL, 32'd0); wr(A_EN, 32'h0000_0060);
    chk("R10 low-active pulse idle", {31'd0, irq_out}, 32'd1);
    wr(A_FRC, 32'h0000_0040);
    chk("R10 low-active pulse asserted", {31'd0, irq_out}, 32'd0);
    step();
    chk("R10 low-active pulse ends", {31'd0, irq_out}, 32'd1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_level();
    t_edge();
    t_set_wins();
    t_force();
    t_out();
    t_pulse();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule